// File: doc/BRIEF.md
# UART Register Bank with Prioritized Interrupts

This block is the processor-facing side of a simple serial port. It has no bit shifter. A 32-bit word bus reaches eight word-spaced registers. Incoming characters arrive one at a time as a byte with a valid strobe and three error flags. Outgoing characters leave as a byte with a valid/ready handshake. The block also tracks four modem-status lines. The divisor, line-control and modem-control values are only stored and exported, for a separate baud and framing engine to use.

Received data is held in a single byte. A byte that arrives while the previous one is still unread replaces it and records an overrun. A registered interrupt output is driven by a four-level fixed-priority encoder over four sources: line errors, received data, transmitter empty and modem changes. The encoder's identification code can be read back over the bus.

Top module: `uart_regfile`

## Requirements
- R1: After a synchronous reset, line status reads 0x60, identification reads 0x1, and the data, modem status and exported configuration values are 0. The interrupt output and transmit valid are low.
- R2: The register index is address bits [4:2]: 0 data, 1 interrupt enable, 2 identification, 3 line control, 4 modem control, 5 line status, 6 modem status, 7 divisor. Read data is registered and appears one cycle after the read strobe. Reads of indices 1, 3, 4 and 7 return 0.
- R3: Writes to indices 1, 3, 4 and 7 store the low bits of the write data. Line control, modem control and divisor are visible on their export ports from the next cycle. Writes to indices 2, 5 and 6 change nothing.
- R4: A received byte sets data ready (line status bit 0). Reading index 0 returns the byte zero-extended and clears data ready.
- R5: A byte that arrives while data ready is set, without a same-cycle read of index 0, sets overrun (bit 1). The new byte replaces the held one.
- R6: The receive-ready output is high exactly while data ready is clear.
- R7: Writing index 0 presents write-data bits [7:0] on the transmit output with valid high. It clears line-status bits 5 and 6 until the valid/ready handshake completes, and then sets both bits again.
- R8: The receive error flags rx_err[0] (parity), rx_err[1] (framing) and rx_err[2] (break) set line-status bits 2, 3 and 4 when a byte arrives. Reading line status clears bits 1 to 4.
- R9: Modem status bits 7:4 are the sampled DCD, RI, DSR and CTS levels. Bits 0 (CTS change), 1 (DSR change), 2 (RI falling edge) and 3 (DCD change) are sticky, and reading modem status clears them.
- R10: Enable bits are 0 receive data, 1 transmit empty, 2 line error and 3 modem. Identification is 0b110 for an enabled line error (any of line-status bits 1 to 4), else 0b100 for enabled data ready, else 0b010 for enabled transmit empty, else 0b000 for an enabled modem delta, else 0b001. The interrupt is high whenever the code is not 0b001.
- R11: The interrupt output and identification register update one cycle after the state that changes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | BYTE_W | Received byte |
| rx_err | input | 3 | Parity, framing, break flags of the byte |
| rx_ready | output | 1 | Holding register free |
| tx_valid | output | 1 | Transmit byte pending |
| tx_data | output | BYTE_W | Transmit byte |
| tx_ready | input | 1 | Transmit sink accepts |
| cts_i | input | 1 | Clear-to-send level |
| dsr_i | input | 1 | Data-set-ready level |
| ri_i | input | 1 | Ring indicator level |
| dcd_i | input | 1 | Carrier detect level |
| irq | output | 1 | Level interrupt |
| line_ctrl | output | LCR_W | Stored line control |
| modem_ctrl | output | MCR_W | Stored modem control |
| divisor | output | DIV_W | Stored baud divisor |

## Verification
The bench uses the default parameters: 32-bit data, a 5-bit byte address, 8-bit characters and a 16-bit divisor. These cover the full register map, so every index, including the write-only and read-only ones, can be reached directly. The 16-bit divisor export lets a value such as 0x1234 be checked without truncation. With 8-bit characters, zero-extension into the 32-bit read word and the 7-bit line status are both visible. A behavioural model compared on every clock covers each interrupt priority, overrun, error clearing and the handshake timing.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_DATA  = 3'd0,
    SEL_IEN   = 3'd1,
    SEL_IDENT = 3'd2,
    SEL_LINE  = 3'd3,
    SEL_MCTL  = 3'd4,
    SEL_LSTAT = 3'd5,
    SEL_MSTAT = 3'd6,
    SEL_DIV   = 3'd7
  } reg_sel_e;

  localparam logic [2:0] ID_LINE_ERR = 3'b110;
  localparam logic [2:0] ID_RX_DATA  = 3'b100;
  localparam logic [2:0] ID_TX_EMPTY = 3'b010;
  localparam logic [2:0] ID_MODEM    = 3'b000;
  localparam logic [2:0] ID_NONE     = 3'b001;

  localparam int EN_RX = 0;
  localparam int EN_TX = 1;
  localparam int EN_LS = 2;
  localparam int EN_MS = 3;

  typedef struct packed {
    logic tx_idle;
    logic tx_hold_empty;
    logic brk;
    logic frame;
    logic parity;
    logic ovr;
    logic ready;
  } line_stat_t;
endpackage

// File: rtl/uart_rf_rxhold.sv
module uart_rf_rxhold #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [2:0]        rx_err,
  input  logic              take,
  input  logic              lstat_rd,
  output logic [BYTE_W-1:0] held,
  output logic              ready,
  output logic              ovr,
  output logic              parity,
  output logic              frame,
  output logic              brk
);
  logic ovr_set;
  assign ovr_set = rx_valid && ready && !take;

  always_ff @(posedge clk) begin
    if (rst) begin
      held   <= '0;
      ready  <= 1'b0;
      ovr    <= 1'b0;
      parity <= 1'b0;
      frame  <= 1'b0;
      brk    <= 1'b0;
    end else begin
      if (rx_valid) held <= rx_byte;
      ready  <= rx_valid | (ready & ~take);
      ovr    <= ovr_set | (ovr & ~lstat_rd);
      parity <= (rx_valid & rx_err[0]) | (parity & ~lstat_rd);
      frame  <= (rx_valid & rx_err[1]) | (frame & ~lstat_rd);
      brk    <= (rx_valid & rx_err[2]) | (brk & ~lstat_rd);
    end
  end
endmodule

// File: rtl/uart_rf_txport.sv
module uart_rf_txport #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic              empty
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else if (load) begin
      tx_valid <= 1'b1;
      tx_data  <= load_byte;
    end else if (tx_valid && tx_ready) begin
      tx_valid <= 1'b0;
    end
  end

  assign empty = ~tx_valid;
endmodule

// File: rtl/uart_rf_modem.sv
module uart_rf_modem (
  input  logic       clk,
  input  logic       rst,
  input  logic       cts_i,
  input  logic       dsr_i,
  input  logic       ri_i,
  input  logic       dcd_i,
  input  logic       clr,
  output logic [7:0] status
);
  logic [3:0] lvl_q;
  logic [3:0] delta_q;
  logic [3:0] now;
  logic [3:0] hit;

  assign now = {dcd_i, ri_i, dsr_i, cts_i};
  assign hit[0] = now[0] ^ lvl_q[0];
  assign hit[1] = now[1] ^ lvl_q[1];
  assign hit[2] = lvl_q[2] & ~now[2];
  assign hit[3] = now[3] ^ lvl_q[3];

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q   <= '0;
      delta_q <= '0;
    end else begin
      lvl_q   <= now;
      delta_q <= hit | (delta_q & ~{4{clr}});
    end
  end

  assign status = {lvl_q, delta_q};
endmodule

// File: rtl/uart_rf_irqenc.sv
module uart_rf_irqenc
  import uart_rf_pkg::*;
#(
  parameter int IEN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  line_stat_t       lsr,
  input  logic [3:0]       mdelta,
  input  logic [IEN_W-1:0] ien,
  output logic             irq,
  output logic [2:0]       ident
);
  logic [2:0] code;

  always_comb begin
    if ((lsr.ovr | lsr.parity | lsr.frame | lsr.brk) && ien[EN_LS])
      code = ID_LINE_ERR;
    else if (lsr.ready && ien[EN_RX])
      code = ID_RX_DATA;
    else if (lsr.tx_hold_empty && ien[EN_TX])
      code = ID_TX_EMPTY;
    else if ((|mdelta) && ien[EN_MS])
      code = ID_MODEM;
    else
      code = ID_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ident <= ID_NONE;
      irq   <= 1'b0;
    end else begin
      ident <= code;
      irq   <= (code != ID_NONE);
    end
  end
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_rf_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int LCR_W  = 7,
  parameter int MCR_W  = 2,
  parameter int DIV_W  = 16,
  parameter int IEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [2:0]        rx_err,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              tx_ready,
  input  logic              cts_i,
  input  logic              dsr_i,
  input  logic              ri_i,
  input  logic              dcd_i,
  output logic              irq,
  output logic [LCR_W-1:0]  line_ctrl,
  output logic [MCR_W-1:0]  modem_ctrl,
  output logic [DIV_W-1:0]  divisor
);
  localparam int IDX_LSB = 2;
  localparam int LSR_W   = $bits(line_stat_t);

  reg_sel_e         sel;
  logic             take, lstat_rd, mstat_rd, tx_load;
  logic [IEN_W-1:0] ien_q;
  logic [BYTE_W-1:0] held;
  logic             rdy, ovr, par, frm, brk, tx_empty;
  logic [7:0]       mstat;
  logic [2:0]       ident;
  line_stat_t       lsr;
  logic [DATA_W-1:0] rd_mux;
  logic             unused_bits;

  assign sel      = reg_sel_e'(bus_addr[IDX_LSB +: SEL_W]);
  assign take     = bus_rd && (sel == SEL_DATA);
  assign lstat_rd = bus_rd && (sel == SEL_LSTAT);
  assign mstat_rd = bus_rd && (sel == SEL_MSTAT);
  assign tx_load  = bus_wr && (sel == SEL_DATA);
  assign unused_bits = ^{bus_addr, bus_wdata};

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q      <= '0;
      line_ctrl  <= '0;
      modem_ctrl <= '0;
      divisor    <= '0;
    end else if (bus_wr) begin
      case (sel)
        SEL_IEN:  ien_q      <= bus_wdata[IEN_W-1:0];
        SEL_LINE: line_ctrl  <= bus_wdata[LCR_W-1:0];
        SEL_MCTL: modem_ctrl <= bus_wdata[MCR_W-1:0];
        SEL_DIV:  divisor    <= bus_wdata[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  uart_rf_rxhold #(.BYTE_W(BYTE_W)) u_rx (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_err(rx_err), .take(take), .lstat_rd(lstat_rd), .held(held),
    .ready(rdy), .ovr(ovr), .parity(par), .frame(frm), .brk(brk)
  );

  uart_rf_txport #(.BYTE_W(BYTE_W)) u_tx (
    .clk(clk), .rst(rst), .load(tx_load), .load_byte(bus_wdata[BYTE_W-1:0]),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .empty(tx_empty)
  );

  uart_rf_modem u_msr (
    .clk(clk), .rst(rst), .cts_i(cts_i), .dsr_i(dsr_i), .ri_i(ri_i),
    .dcd_i(dcd_i), .clr(mstat_rd), .status(mstat)
  );

  always_comb begin
    lsr.tx_idle       = tx_empty;
    lsr.tx_hold_empty = tx_empty;
    lsr.brk           = brk;
    lsr.frame         = frm;
    lsr.parity        = par;
    lsr.ovr           = ovr;
    lsr.ready         = rdy;
  end

  uart_rf_irqenc #(.IEN_W(IEN_W)) u_irq (
    .clk(clk), .rst(rst), .lsr(lsr), .mdelta(mstat[3:0]), .ien(ien_q),
    .irq(irq), .ident(ident)
  );

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_DATA:  rd_mux[BYTE_W-1:0] = held;
      SEL_IDENT: rd_mux[2:0]        = ident;
      SEL_LSTAT: rd_mux[LSR_W-1:0]  = lsr;
      SEL_MSTAT: rd_mux[7:0]        = mstat;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
    else             bus_rdata <= '0;
  end

  assign rx_ready = ~rdy;
endmodule

// File: rtl/uart_rf_chk.sv
module uart_rf_chk #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int IEN_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              tx_valid,
  input logic [BYTE_W-1:0] tx_data,
  input logic              tx_ready,
  input logic              irq,
  input logic [IEN_W-1:0]  ien_q
);
  logic [2:0] idx;
  logic       wr_data, rd_wo;
  assign idx     = bus_addr[4:2];
  assign wr_data = bus_wr && (idx == 3'd0);
  assign rd_wo   = bus_rd && (idx == 3'd1 || idx == 3'd3 || idx == 3'd4 || idx == 3'd7);

  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> (!irq && !tx_valid));
  p_wo_reads_zero_r2: assert property (@(posedge clk) disable iff (rst)
    rd_wo |=> (bus_rdata == '0));
  p_rx_busy_r6: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_ready);
  p_tx_load_r7: assert property (@(posedge clk) disable iff (rst)
    wr_data |=> (tx_valid && tx_data == $past(bus_wdata[BYTE_W-1:0])));
  p_tx_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready && !wr_data) |=> (tx_valid && $stable(tx_data)));
  p_tx_done_r7: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready && !wr_data) |=> !tx_valid);
  p_no_enable_no_irq_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(ien_q) == '0) |-> !irq);
endmodule

bind uart_regfile uart_rf_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W), .IEN_W(IEN_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .tx_valid(tx_valid),
  .tx_data(tx_data), .tx_ready(tx_ready), .irq(irq), .ien_q(ien_q)
);

// File: tb/uart_regfile_tb.sv
module uart_regfile_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic [2:0]  rx_err = '0;
  logic        rx_ready, tx_valid, tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic        cts_i = 0, dsr_i = 0, ri_i = 0, dcd_i = 0;
  logic        irq;
  logic [6:0]  line_ctrl;
  logic [1:0]  modem_ctrl;
  logic [15:0] divisor;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uart_regfile u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_err(rx_err),
    .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .cts_i(cts_i), .dsr_i(dsr_i), .ri_i(ri_i),
    .dcd_i(dcd_i), .irq(irq), .line_ctrl(line_ctrl),
    .modem_ctrl(modem_ctrl), .divisor(divisor)
  );

  // reference model state
  logic [7:0]  m_held;
  logic        m_dr, m_oe, m_pe, m_fe, m_bi, m_txv;
  logic [7:0]  m_txd;
  logic [3:0]  m_ien, m_lvl, m_dl;
  logic [6:0]  m_lcr;
  logic [1:0]  m_mcr;
  logic [15:0] m_div;
  logic        m_irq;
  logic [2:0]  m_id;
  logic [31:0] m_rdata;

  always @(posedge clk) begin
    logic [2:0] ix;
    logic [6:0] lsr_o;
    logic [3:0] now;
    logic take, lrd, mrd;
    ix = bus_addr[4:2];
    if (rst) begin
      m_held = 0; m_dr = 0; m_oe = 0; m_pe = 0; m_fe = 0; m_bi = 0;
      m_txv = 0; m_txd = 0; m_ien = 0; m_lvl = 0; m_dl = 0;
      m_lcr = 0; m_mcr = 0; m_div = 0; m_irq = 0; m_id = 3'b001; m_rdata = 0;
    end else begin
      lsr_o = {~m_txv, ~m_txv, m_bi, m_fe, m_pe, m_oe, m_dr};
      m_rdata = 0;
      if (bus_rd) begin
        if (ix == 0) m_rdata = {24'd0, m_held};
        if (ix == 2) m_rdata = {29'd0, m_id};
        if (ix == 5) m_rdata = {25'd0, lsr_o};
        if (ix == 6) m_rdata = {24'd0, m_lvl, m_dl};
      end
      if ((m_oe || m_pe || m_fe || m_bi) && m_ien[2]) m_id = 3'b110;
      else if (m_dr && m_ien[0])                       m_id = 3'b100;
      else if (!m_txv && m_ien[1])                     m_id = 3'b010;
      else if (m_dl != 0 && m_ien[3])                  m_id = 3'b000;
      else                                             m_id = 3'b001;
      m_irq = (m_id != 3'b001);
      take = bus_rd && ix == 0;
      lrd  = bus_rd && ix == 5;
      mrd  = bus_rd && ix == 6;
      if (lrd) begin m_oe = 0; m_pe = 0; m_fe = 0; m_bi = 0; end
      if (take) m_dr = 0;
      if (rx_valid) begin
        if (m_dr) m_oe = 1;
        m_dr = 1; m_held = rx_byte;
        if (rx_err[0]) m_pe = 1;
        if (rx_err[1]) m_fe = 1;
        if (rx_err[2]) m_bi = 1;
      end
      if (bus_wr && ix == 0) begin m_txv = 1; m_txd = bus_wdata[7:0]; end
      else if (m_txv && tx_ready) m_txv = 0;
      if (bus_wr && ix == 1) m_ien = bus_wdata[3:0];
      if (bus_wr && ix == 3) m_lcr = bus_wdata[6:0];
      if (bus_wr && ix == 4) m_mcr = bus_wdata[1:0];
      if (bus_wr && ix == 7) m_div = bus_wdata[15:0];
      now = {dcd_i, ri_i, dsr_i, cts_i};
      if (mrd) m_dl = 0;
      m_dl[0] = m_dl[0] | (now[0] ^ m_lvl[0]);
      m_dl[1] = m_dl[1] | (now[1] ^ m_lvl[1]);
      m_dl[2] = m_dl[2] | (m_lvl[2] & ~now[2]);
      m_dl[3] = m_dl[3] | (now[3] ^ m_lvl[3]);
      m_lvl = now;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // continuous comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 R4 rdata", bus_rdata, m_rdata);
      chk("R11 irq", {31'd0, irq}, {31'd0, m_irq});
      chk("R7 tx_valid", {31'd0, tx_valid}, {31'd0, m_txv});
      if (m_txv) chk("R7 tx_data", {24'd0, tx_data}, {24'd0, m_txd});
      chk("R6 rx_ready", {31'd0, rx_ready}, {31'd0, ~m_dr});
      chk("R3 exports", {7'd0, line_ctrl, modem_ctrl, divisor},
          {7'd0, m_lcr, m_mcr, m_div});
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] ix, logic [31:0] d);
    @(negedge clk);
    bus_addr = {ix, 2'b00}; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [2:0] ix, logic [31:0] exp, string req);
    @(negedge clk);
    bus_addr = {ix, 2'b00}; bus_rd = 1;
    @(negedge clk);
    bus_rd = 0;
    chk(req, bus_rdata, exp);
  endtask

  task automatic rx(logic [7:0] b, logic [2:0] e);
    @(negedge clk);
    rx_valid = 1; rx_byte = b; rx_err = e;
    @(negedge clk);
    rx_valid = 0; rx_err = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst = 0;
    idle(2);
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    rd(3'd5, 32'h60, "R1 line status reset");
    rd(3'd2, 32'h1,  "R1 ident reset");
    rd(3'd0, 32'h0,  "R1 data reset");
    rd(3'd6, 32'h0,  "R1 modem status reset");

    wr(3'd3, 32'hFFFF_FF1B);
    wr(3'd4, 32'h3);
    wr(3'd7, 32'hABCD_1234);
    wr(3'd1, 32'hF);
    idle(2);
    chk("R3 line_ctrl export", {25'd0, line_ctrl}, 32'h1B);
    chk("R3 divisor export", {16'd0, divisor}, 32'h1234);
    rd(3'd1, 32'h0, "R2 ien reads zero");
    rd(3'd3, 32'h0, "R2 lcr reads zero");
    rd(3'd7, 32'h0, "R2 div reads zero");
    rd(3'd2, 32'h2, "R10 tx empty id");
    chk("R10 irq for tx empty", {31'd0, irq}, 32'd1);

    wr(3'd5, 32'hFF);
    wr(3'd6, 32'hFF);
    wr(3'd2, 32'h7);
    rd(3'd5, 32'h60, "R3 read-only lstat unchanged");
    rd(3'd6, 32'h0,  "R3 read-only mstat unchanged");

    rx(8'hA5, 3'b000);
    chk("R6 rx_ready low when held", {31'd0, rx_ready}, 32'd0);
    idle(1);
    rd(3'd2, 32'h4,  "R10 rx data id");
    rd(3'd5, 32'h61, "R4 data ready set");
    rd(3'd0, 32'hA5, "R4 data byte");
    rd(3'd5, 32'h60, "R4 data ready cleared");
    chk("R6 rx_ready high when free", {31'd0, rx_ready}, 32'd1);

    rx(8'h11, 3'b000);
    rx(8'h22, 3'b000);
    idle(1);
    rd(3'd2, 32'h6,  "R10 line error id");
    rd(3'd5, 32'h63, "R5 overrun set");
    rd(3'd5, 32'h61, "R8 overrun cleared by read");
    rd(3'd0, 32'h22, "R5 newest byte kept");

    rx(8'h5A, 3'b011);
    idle(1);
    rd(3'd5, 32'h6D, "R8 parity and framing");
    rd(3'd5, 32'h61, "R8 errors cleared");
    rd(3'd0, 32'h5A, "R4 byte with errors");
    rx(8'h00, 3'b100);
    idle(1);
    rd(3'd5, 32'h71, "R8 break");
    rd(3'd0, 32'h00, "R4 break byte");

    tx_ready = 0;
    wr(3'd0, 32'h1234_563C);
    chk("R7 tx valid", {31'd0, tx_valid}, 32'd1);
    chk("R7 tx byte", {24'd0, tx_data}, 32'h3C);
    idle(1);
    rd(3'd5, 32'h00, "R7 holding not empty");
    rd(3'd2, 32'h1,  "R10 no source while busy");
    @(negedge clk); tx_ready = 1;
    @(negedge clk); tx_ready = 0;
    chk("R7 tx handshake done", {31'd0, tx_valid}, 32'd0);
    rd(3'd5, 32'h60, "R7 empty again");

    @(negedge clk); cts_i = 1;
    idle(2);
    rd(3'd2, 32'h2,  "R10 tx empty beats modem");
    wr(3'd1, 32'h8);
    idle(1);
    rd(3'd2, 32'h0,  "R10 modem id");
    rd(3'd6, 32'h11, "R9 cts level and change");
    rd(3'd6, 32'h10, "R9 deltas cleared");
    idle(1);
    chk("R11 irq dropped", {31'd0, irq}, 32'd0);
    @(negedge clk); ri_i = 1;
    idle(2);
    @(negedge clk); ri_i = 0;
    idle(2);
    rd(3'd6, 32'h14, "R9 ri trailing edge");
    @(negedge clk); dcd_i = 1; dsr_i = 1;
    idle(2);
    rd(3'd6, 32'hBA, "R9 dcd dsr change");
    wr(3'd1, 32'h0);
    idle(2);
    chk("R10 all disabled", {31'd0, irq}, 32'd0);
    idle(2);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule